// File: doc/BRIEF.md
# Two-Phase Scan Test Sequencer

This block sequences a hybrid scan test in two phases. In the first phase it loads pseudo-random seeds from the tester. The address register is switched to counter mode for this phase, so each seed bit needs one cycle. After each seed it runs a programmable number of capture cycles. It keeps doing this while the tester reports that another seed is waiting.

Once the seeds are used up, it switches the address register to shift mode and enters the random-access phase. Each bit flip is built from one tester address bit per cycle, followed by a single toggle cycle that inverts the addressed cell. When the tester marks a flip as the last one of a test cube, the block runs one capture cycle. It then asks whether another cube follows.

Tester data arrives over a valid/ready handshake. The block drives the address-register mode select and the address and scan clock enables, plus a capture enable. It counts completed seed loads.

The seed length, the capture length and the two "more" indicators are run-time inputs. The configuration inputs must be held stable while a run is in progress. The seed length must be at least 1. The address width is a parameter.

Top module: `scan_seq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `t_ready`, `aclk_en`, `sclk_en`, `cap_en`, `addr_mode` and `done` are 0, and `seed_count` is 0.
- R2: A `start` pulse seen while idle or done begins a seed load in the next cycle with `addr_mode`=1 and clears `seed_count`. A `start` pulse while a run is in progress has no effect on the sequence.
- R3: During a seed load, every accepted tester bit (`t_valid` and `t_ready` both 1) raises `aclk_en` and `sclk_en` together in that cycle, with `scan_di` equal to `t_data`. Neither enable is raised in a cycle with no acceptance. The load ends after exactly `cfg_seed_len` accepted bits.
- R4: After each seed load, `cap_en` is high for exactly `cfg_test_len` consecutive cycles. When `cfg_test_len` is 0, no capture cycle occurs and the sequence goes straight to the seed check. `t_ready` is 0 in every capture cycle.
- R5: In the one-cycle seed check, `more_seeds`=1 starts another seed load and `more_seeds`=0 starts the random-access phase. `addr_mode` falls only at that point. `seed_count` rises by one per completed seed load.
- R6: In the random-access phase `addr_mode` is 0. Each flip is made of `ADDR_W` accepted bits, each with `aclk_en`=1 and `sclk_en`=0. It is followed by one toggle cycle with `sclk_en`=1, `aclk_en`=0 and `t_ready`=0. The two enables are never high together.
- R7: `t_last`=1 on the final address bit of a flip marks the cube as complete. After that flip's toggle cycle comes exactly one capture cycle. `t_last` on any other address bit is ignored.
- R8: After a cube's capture cycle, a one-cycle check follows. There `more_cubes`=1 starts the next flip and `more_cubes`=0 raises `done`. `done` then stays high, with every enable and `t_ready` at 0, until a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse to begin a run (idle or done only) |
| cfg_seed_len | input | SEED_LEN_W | Seed length in bits (at least 1) |
| cfg_test_len | input | TEST_LEN_W | Capture cycles per seed (0 allowed) |
| more_seeds | input | 1 | Tester has another seed, sampled at the seed check |
| more_cubes | input | 1 | Tester has another cube, sampled at the cube check |
| t_valid | input | 1 | Tester data valid |
| t_ready | output | 1 | Block accepts a tester bit this cycle |
| t_data | input | 1 | Tester data bit (seed bit or address bit) |
| t_last | input | 1 | Final address bit of the last flip of a cube |
| addr_mode | output | 1 | Address register mode: 1 counter, 0 shift |
| aclk_en | output | 1 | Address register clock enable |
| sclk_en | output | 1 | Scan cell write/toggle clock enable |
| cap_en | output | 1 | Response capture enable |
| scan_di | output | 1 | Serial data to the address register / cells |
| seed_count | output | SEED_CNT_W | Seeds loaded in the current run |
| done | output | 1 | Run complete, held until the next start |

## Verification
Several corner cases are targeted on purpose:

- A zero capture length. A design that mishandles it would emit one capture cycle per seed, or wrap its counter into a very long run.
- Gaps in `t_valid`. A design that counted cycles instead of accepted bits would end the seed load or the flip early, and the enable totals would come up short.
- An early `t_last` on the first address bit of a non-final flip. A design that honoured it would capture too soon and lose flips.
- A `start` pulse in mid-run. A design that accepted it would reload seeds and overshoot the expected counts.

A one-bit seed and a single-flip cube test the off-by-one edges of the bit counters. A held `done` and a reset in mid-run are checked for stray enables.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_SEED_LOAD = 4'd1,
    ST_SEED_RUN  = 4'd2,
    ST_SEED_CHK  = 4'd3,
    ST_FLIP_ADDR = 4'd4,
    ST_FLIP_SET  = 4'd5,
    ST_CUBE_TEST = 4'd6,
    ST_CUBE_CHK  = 4'd7,
    ST_DONE      = 4'd8
  } ssc_state_e;

  function automatic logic in_seed_phase(input ssc_state_e s);
    return (s == ST_SEED_LOAD) || (s == ST_SEED_RUN) || (s == ST_SEED_CHK);
  endfunction

  function automatic logic takes_data(input ssc_state_e s);
    return (s == ST_SEED_LOAD) || (s == ST_FLIP_ADDR);
  endfunction

endpackage

// File: rtl/ssc_counter.sv
module ssc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/ssc_fsm.sv
module ssc_fsm
  import scan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       seed_wrap,
  input  logic       addr_wrap,
  input  logic       test_last,
  input  logic       len_zero,
  input  logic       more_seeds,
  input  logic       more_cubes,
  input  logic       t_last,
  output ssc_state_e st
);

  ssc_state_e st_d;
  logic       cube_end_q;
  logic       cube_end_d;
  logic       cube_end_en;

  always_comb begin
    st_d = st;
    unique case (st)
      ST_IDLE, ST_DONE: if (start) st_d = ST_SEED_LOAD;
      ST_SEED_LOAD:     if (seed_wrap) st_d = len_zero ? ST_SEED_CHK : ST_SEED_RUN;
      ST_SEED_RUN:      if (test_last) st_d = ST_SEED_CHK;
      ST_SEED_CHK:      st_d = more_seeds ? ST_SEED_LOAD : ST_FLIP_ADDR;
      ST_FLIP_ADDR:     if (addr_wrap) st_d = ST_FLIP_SET;
      ST_FLIP_SET:      st_d = cube_end_q ? ST_CUBE_TEST : ST_FLIP_ADDR;
      ST_CUBE_TEST:     st_d = ST_CUBE_CHK;
      ST_CUBE_CHK:      st_d = more_cubes ? ST_FLIP_ADDR : ST_DONE;
      default:          st_d = ST_IDLE;
    endcase
  end

  // the last address bit of a flip carries the cube-complete mark
  always_comb begin
    cube_end_en = addr_wrap;
    cube_end_d  = t_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      st <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cube_end_q <= 1'b0;
    end else if (cube_end_en) begin
      cube_end_q <= cube_end_d;
    end
  end

endmodule

// File: rtl/ssc_outdec.sv
module ssc_outdec
  import scan_seq_pkg::*;
(
  input  ssc_state_e st,
  input  logic       t_valid,
  input  logic       t_data,
  output logic       t_ready,
  output logic       addr_mode,
  output logic       aclk_en,
  output logic       sclk_en,
  output logic       cap_en,
  output logic       scan_di,
  output logic       done
);

  always_comb begin
    t_ready   = takes_data(st);
    addr_mode = in_seed_phase(st);
    aclk_en   = t_ready & t_valid;
    sclk_en   = ((st == ST_SEED_LOAD) & t_valid) | (st == ST_FLIP_SET);
    cap_en    = (st == ST_SEED_RUN) | (st == ST_CUBE_TEST);
    scan_di   = t_ready & t_data;
    done      = (st == ST_DONE);
  end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int SEED_LEN_W = 8,
  parameter int TEST_LEN_W = 10,
  parameter int SEED_CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SEED_LEN_W-1:0] cfg_seed_len,
  input  logic [TEST_LEN_W-1:0] cfg_test_len,
  input  logic                  more_seeds,
  input  logic                  more_cubes,
  input  logic                  t_valid,
  output logic                  t_ready,
  input  logic                  t_data,
  input  logic                  t_last,
  output logic                  addr_mode,
  output logic                  aclk_en,
  output logic                  sclk_en,
  output logic                  cap_en,
  output logic                  scan_di,
  output logic [SEED_CNT_W-1:0] seed_count,
  output logic                  done
);

  localparam int ADDR_CW = $clog2(ADDR_W + 1);
  localparam int BIT_W   = (SEED_LEN_W > ADDR_CW) ? SEED_LEN_W : ADDR_CW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  ssc_state_e            st;
  logic                  xfer;
  logic                  run_go;
  logic [BIT_W-1:0]      bit_cnt;
  logic [BIT_W:0]        bit_nxt;
  logic [TEST_LEN_W-1:0] test_cnt;
  logic                  seed_wrap;
  logic                  addr_wrap;
  logic                  test_last;
  logic                  len_zero;

  always_comb begin
    xfer      = t_valid & t_ready;
    run_go    = start & ((st == ST_IDLE) | (st == ST_DONE));
    bit_nxt   = (BIT_W+1)'(bit_cnt) + (BIT_W+1)'(1);
    seed_wrap = xfer & (st == ST_SEED_LOAD) & (bit_nxt == (BIT_W+1)'(cfg_seed_len));
    addr_wrap = xfer & (st == ST_FLIP_ADDR) & (bit_nxt == (BIT_W+1)'(ADDR_W));
    len_zero  = (cfg_test_len == '0);
    test_last = (st == ST_SEED_RUN) &
                (((TEST_LEN_W+1)'(test_cnt) + (TEST_LEN_W+1)'(1)) ==
                 (TEST_LEN_W+1)'(cfg_test_len));
  end

  // scan-in bit counter: seed bits in the first phase, address bits later
  ssc_counter #(.W(BIT_W)) u_bit_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (run_go | seed_wrap | addr_wrap),
    .inc   (xfer),
    .cnt   (bit_cnt)
  );

  // capture cycle counter for the seed phase
  ssc_counter #(.W(TEST_LEN_W)) u_test_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (st != ST_SEED_RUN),
    .inc   (st == ST_SEED_RUN),
    .cnt   (test_cnt)
  );

  // completed seed loads in this run
  ssc_counter #(.W(SEED_CNT_W)) u_seed_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (run_go),
    .inc   (seed_wrap),
    .cnt   (seed_count)
  );

  ssc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .seed_wrap  (seed_wrap),
    .addr_wrap  (addr_wrap),
    .test_last  (test_last),
    .len_zero   (len_zero),
    .more_seeds (more_seeds),
    .more_cubes (more_cubes),
    .t_last     (t_last),
    .st         (st)
  );

  ssc_outdec u_out (
    .st        (st),
    .t_valid   (t_valid),
    .t_data    (t_data),
    .t_ready   (t_ready),
    .addr_mode (addr_mode),
    .aclk_en   (aclk_en),
    .sclk_en   (sclk_en),
    .cap_en    (cap_en),
    .scan_di   (scan_di),
    .done      (done)
  );

endmodule

// File: rtl/ssc_chk.sv
module ssc_chk
  import scan_seq_pkg::*;
#(
  parameter int SEED_CNT_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  t_valid,
  input logic                  t_ready,
  input logic                  more_seeds,
  input logic                  addr_mode,
  input logic                  aclk_en,
  input logic                  sclk_en,
  input logic                  cap_en,
  input logic                  done,
  input logic [SEED_CNT_W-1:0] seed_count,
  input ssc_state_e            st
);

  p_start_enters_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && ($past(st) == ST_IDLE || $past(st) == ST_DONE)) |-> addr_mode);

  p_seed_bit_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode && aclk_en) |-> (sclk_en && t_valid && t_ready));

  p_seed_no_idle_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode && sclk_en) |-> aclk_en);

  p_capture_blocks_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !t_ready);

  p_phase_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_mode) |-> !$past(more_seeds));

  p_seed_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_count != $past(seed_count)) |->
      ((seed_count == SEED_CNT_W'($past(seed_count) + 1'b1)) || (seed_count == '0)));

  p_flip_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mode |-> !(aclk_en && sclk_en));

  p_toggle_after_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_mode && sclk_en) |-> ($past(aclk_en) && !t_ready));

  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!aclk_en && !sclk_en && !cap_en && !t_ready));

endmodule

bind scan_seq_ctrl ssc_chk #(.SEED_CNT_W(SEED_CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .t_valid    (t_valid),
  .t_ready    (t_ready),
  .more_seeds (more_seeds),
  .addr_mode  (addr_mode),
  .aclk_en    (aclk_en),
  .sclk_en    (sclk_en),
  .cap_en     (cap_en),
  .done       (done),
  .seed_count (seed_count),
  .st         (st)
);

// File: tb/scan_seq_ctrl_tb_top.sv
module scan_seq_ctrl_tb_top;

  localparam int CLK_P      = 10;
  localparam int ADDR_W     = 4;
  localparam int SEED_LEN_W = 8;
  localparam int TEST_LEN_W = 10;
  localparam int SEED_CNT_W = 8;
  localparam int ROWS       = 6;
  localparam int RUN_LIMIT  = 5000;

  // columns: seed_len, test_len, seeds, cubes, flips_per_cube, gaps, busy_start, early_last
  localparam int TBL [ROWS][8] = '{
    '{4, 3,  2, 2, 2, 0, 0, 0},
    '{5, 0,  1, 1, 1, 0, 0, 0},
    '{1, 1,  3, 3, 1, 0, 0, 0},
    '{3, 2,  2, 2, 3, 1, 0, 0},
    '{2, 4,  1, 2, 2, 0, 1, 1},
    '{8, 16, 2, 1, 4, 0, 0, 0}
  };

  logic                  clk;
  logic                  rst_n;
  logic                  start;
  logic [SEED_LEN_W-1:0] cfg_seed_len;
  logic [TEST_LEN_W-1:0] cfg_test_len;
  logic                  more_seeds;
  logic                  more_cubes;
  logic                  t_valid;
  logic                  t_ready;
  logic                  t_data;
  logic                  t_last;
  logic                  addr_mode;
  logic                  aclk_en;
  logic                  sclk_en;
  logic                  cap_en;
  logic                  scan_di;
  logic [SEED_CNT_W-1:0] seed_count;
  logic                  done;

  int total;
  int bad;

  scan_seq_ctrl #(
    .ADDR_W     (ADDR_W),
    .SEED_LEN_W (SEED_LEN_W),
    .TEST_LEN_W (TEST_LEN_W),
    .SEED_CNT_W (SEED_CNT_W)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_seed_len (cfg_seed_len),
    .cfg_test_len (cfg_test_len),
    .more_seeds   (more_seeds),
    .more_cubes   (more_cubes),
    .t_valid      (t_valid),
    .t_ready      (t_ready),
    .t_data       (t_data),
    .t_last       (t_last),
    .addr_mode    (addr_mode),
    .aclk_en      (aclk_en),
    .sclk_en      (sclk_en),
    .cap_en       (cap_en),
    .scan_di      (scan_di),
    .seed_count   (seed_count),
    .done         (done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_quiet(input string req);
    check(!t_ready && !aclk_en && !sclk_en && !cap_en, {req, " enables low"},
          {t_ready, aclk_en, sclk_en, cap_en}, 0);
  endtask

  task automatic run_row(input int r);
    int m, len, ns, nc, fl, gap, busy, early;
    int seed_acc, ra_acc, cyc;
    int s_aclk, s_cap, r_aclk, r_sclk, r_cap, viol, dmis, first_mode;
    int ra_bit, flip_idx, exp_cyc;
    bit seen_done;
    m = TBL[r][0]; len = TBL[r][1]; ns = TBL[r][2]; nc = TBL[r][3];
    fl = TBL[r][4]; gap = TBL[r][5]; busy = TBL[r][6]; early = TBL[r][7];
    seed_acc = 0; ra_acc = 0; cyc = 0; s_aclk = 0; s_cap = 0; r_aclk = 0;
    r_sclk = 0; r_cap = 0; viol = 0; dmis = 0; first_mode = 0; seen_done = 0;
    @(negedge clk);
    cfg_seed_len = SEED_LEN_W'(m);
    cfg_test_len = TEST_LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < RUN_LIMIT; k++) begin
      t_valid    = (gap != 0) ? ((k % 2) == 0) : 1'b1;
      t_data     = ((seed_acc + ra_acc) % 3) == 1;
      ra_bit     = ra_acc % ADDR_W;
      flip_idx   = (ra_acc / ADDR_W) % fl;
      t_last     = ((ra_bit == ADDR_W - 1) && (flip_idx == fl - 1)) ||
                   ((early != 0) && (ra_bit == 0) && (flip_idx != fl - 1));
      more_seeds = (seed_acc / m) < ns;
      more_cubes = (ra_acc / (ADDR_W * fl)) < nc;
      start      = (busy != 0) && (k == 6);
      #1;
      if (k == 0) first_mode = addr_mode;
      if (done) begin
        seen_done = 1'b1;
        break;
      end
      cyc++;
      if (aclk_en && (scan_di != t_data)) dmis++;
      if (cap_en && t_ready) viol++;
      if (addr_mode) begin
        if (aclk_en != sclk_en) viol++;
        if (aclk_en) s_aclk++;
        if (cap_en) s_cap++;
        if (t_valid && t_ready) seed_acc++;
      end else begin
        if (aclk_en && sclk_en) viol++;
        if (sclk_en && t_ready) viol++;
        if (aclk_en) r_aclk++;
        if (sclk_en) r_sclk++;
        if (cap_en) r_cap++;
        if (t_valid && t_ready) ra_acc++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(seen_done, "R8 run reaches done", seen_done, 1);
    check(first_mode == 1, "R2 first cycle after start is seed load", first_mode, 1);
    check(s_aclk == ns * m, "R3 seed bits clocked", s_aclk, ns * m);
    check(dmis == 0, "R3 scan_di follows t_data", dmis, 0);
    check(s_cap == ns * len, "R4 seed capture cycles", s_cap, ns * len);
    check(int'(seed_count) == ns, "R5 seed_count", seed_count, ns);
    check(r_aclk == nc * fl * ADDR_W, "R6 address bits clocked", r_aclk, nc * fl * ADDR_W);
    check(r_sclk == nc * fl, "R6 toggle cycles", r_sclk, nc * fl);
    check(viol == 0, "R6 enable overlap or ready in capture/toggle", viol, 0);
    check(r_cap == nc, "R7 one capture per cube", r_cap, nc);
    if (gap == 0) begin
      exp_cyc = ns * (m + len + 1) + nc * (fl * (ADDR_W + 1) + 2);
      check(cyc == exp_cyc, "R8 cycles from start to done", cyc, exp_cyc);
    end
    for (int h = 0; h < 5; h++) begin
      @(negedge clk);
      #1;
      check(done == 1'b1, "R8 done held", done, 1);
      check_quiet("R8 done");
    end
  endtask

  initial begin
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    start = 1'b0;
    cfg_seed_len = SEED_LEN_W'(4);
    cfg_test_len = TEST_LEN_W'(2);
    more_seeds = 1'b0;
    more_cubes = 1'b0;
    t_valid = 1'b1;
    t_data = 1'b0;
    t_last = 1'b0;
    #(CLK_P * 3 + 2);
    check_quiet("R1 in reset");
    check(!done && !addr_mode && seed_count == '0, "R1 in reset state", {done, addr_mode}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check_quiet("R1 after release");
    check(!done && !addr_mode && seed_count == '0, "R1 idle state", {done, addr_mode}, 0);

    for (int r = 0; r < ROWS; r++) run_row(r);

    // R1: reset in the middle of a run returns to a quiet idle state
    @(negedge clk);
    cfg_seed_len = SEED_LEN_W'(6);
    cfg_test_len = TEST_LEN_W'(3);
    more_seeds = 1'b1;
    t_valid = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_quiet("R1 mid-run reset");
    check(!done && !addr_mode && seed_count == '0, "R1 mid-run reset state",
          {done, addr_mode, seed_count}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!addr_mode && !t_ready, "R1 stays idle without start", {addr_mode, t_ready}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule